// File: doc/BRIEF.md
# Direct Digital Synthesizer with Output Width Fitting

The block produces a stream of signed sine samples whose frequency is set by a tuning word. A phase register adds the tuning word once for each sample the downstream converter accepts. The upper bits of the phase go to a quarter-wave amplitude table, which is mirrored across the four quadrants. The signed sine value is then fitted to an output width chosen on its own. A narrower output is rounded to even on the discarded bits and saturated at positive full scale. A wider output is shifted left. An output of the same width as the table passes through unchanged.

The phase width can be set from 8 to 24 bits. The phase register has no reset. While `en` is low it is held at the start phase. While `en` is high it advances on each cycle in which `valid` is high. A sample is produced for every cycle in which `en` and `valid` are both high. It leaves the block three clock edges later, marked by `out_valid`.

Top module: `dds_synth`

## Requirements
- R1: On every rising edge at which `en` and `valid` are both 1, the phase advances by `step`, modulo 2^PHASE_W. Consecutive samples therefore use the phases start, start+step, start+2·step, and so on, wrapping at 2^PHASE_W.
- R2: While `en` is 0, the phase is loaded with `start`. The first sample after `en` returns to 1 uses exactly `start`.
- R3: A cycle in which `en` is 1 and `valid` is 0 leaves the phase unchanged and produces no sample.
- R4: `out_valid` is 1 exactly three rising edges after an edge that sampled `en`=1 and `valid`=1, counting that edge as the first, and is 0 otherwise. While `rst` is 1 and for the next three edges, `out_valid` is 0.
- R5: The internal sine value of a sample is formed from the phase bits used as the index (see R10). Let q be the top two of those bits and i the next LUT_AW bits, and let k = q·2^LUT_AW + i. The value is sign(k)·round((2^(SINE_W-1)−1)·|sin(2π(k+0.5)/2^(LUT_AW+2))|). It is negative when q is 2 or 3 and is coded in two's complement.
- R6: When OUT_W < SINE_W, the output is the sine value divided by 2^(SINE_W−OUT_W) and rounded to the nearest integer. An exact tie rounds to the even result.
- R7: When rounding in R6 would exceed 2^(OUT_W−1)−1, the output is held at 2^(OUT_W−1)−1.
- R8: When OUT_W > SINE_W, the output is the sine value multiplied by 2^(OUT_W−SINE_W), with zeros in the low bits.
- R9: When OUT_W = SINE_W, the output equals the sine value exactly.
- R10: Only the top LUT_AW+2 phase bits select the sample. Phases that differ only in the lower bits give the same output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset for the sample-valid pipeline |
| en | input | 1 | Run enable; while low, the phase is held at `start` |
| valid | input | 1 | Downstream converter accepts a sample this cycle |
| step | input | PHASE_W | Tuning word added per accepted sample |
| start | input | PHASE_W | Start phase loaded while `en` is low |
| out_valid | output | 1 | Output sample is valid |
| out_sample | output | OUT_W | Signed sine sample in two's complement |

## Verification
The bench drives one phase stream into three copies of the block: one narrower than the table, one equal and one wider. A full sweep makes the narrow copy meet exact half-step ties and the peak codes that round past full scale. A design that truncated, rounded ties upward or skipped saturation would give an off-by-one value or a sign flip at the crest. The sweep also runs over every quadrant and over odd and even phases. This exposes a mirror with the wrong index or sign, and any use of the phase bits below the table index. Tuning words that wrap, gaps in `valid` and a drop of `en` followed by a new start phase check that the phase advances only on accepted samples and reloads cleanly. The three-edge latency of `out_valid` is checked on every cycle.

// File: rtl/dds_pkg.sv
package dds_pkg;

    localparam real DDS_PI = 3.14159265358979323846;

    // Quadrant taken from the top two index bits
    typedef enum logic [1:0] {
        QD_RISE_POS = 2'd0,
        QD_FALL_POS = 2'd1,
        QD_FALL_NEG = 2'd2,
        QD_RISE_NEG = 2'd3
    } quad_e;

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int PHASE_W = 16,
    parameter int IDX_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               valid,
    input  logic [PHASE_W-1:0] step,
    input  logic [PHASE_W-1:0] start,
    output logic               vld_o,
    output logic [IDX_W-1:0]   idx_o
);

    logic [PHASE_W-1:0] acc;

    // Phase register: no reset, loaded while disabled
    always_ff @(posedge clk) begin
        if (!en) begin
            acc <= start;
        end else if (valid) begin
            acc <= acc + step;
        end
    end

    // Stage 1: capture the index bits of the current phase
    always_ff @(posedge clk) begin
        idx_o <= acc[PHASE_W-1 -: IDX_W];
        if (rst) begin
            vld_o <= 1'b0;
        end else begin
            vld_o <= en && valid;
        end
    end

    // R3
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !valid) |=> $stable(acc));

    // R2
    phase_load_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (acc == $past(start)));

endmodule

// File: rtl/dds_quarter_sine.sv
module dds_quarter_sine
    import dds_pkg::*;
#(
    parameter int LUT_AW = 6,
    parameter int SINE_W = 14
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     vld_i,
    input  logic [LUT_AW+1:0]        idx_i,
    output logic                     vld_o,
    output logic signed [SINE_W-1:0] sine_o
);

    localparam int  N_ENT = 1 << LUT_AW;
    localparam int  MAG_W = SINE_W - 1;
    localparam real AMP   = real'((1 << (SINE_W - 1)) - 1);

    logic [MAG_W-1:0] rom [N_ENT];

    // Quarter-wave table sampled at half-step offsets
    for (genvar j = 0; j < N_ENT; j++) begin : g_rom
        localparam real ANG = 2.0 * DDS_PI * (real'(j) + 0.5) / (4.0 * real'(N_ENT));
        localparam int  VAL = $rtoi(AMP * $sin(ANG) + 0.5);
        assign rom[j] = MAG_W'(VAL);
    end

    quad_e             quad;
    logic [LUT_AW-1:0] addr;
    logic              neg;

    assign quad = quad_e'(idx_i[LUT_AW+1:LUT_AW]);

    always_comb begin
        addr = idx_i[LUT_AW-1:0];
        neg  = 1'b0;
        unique case (quad)
            QD_RISE_POS: begin
                addr = idx_i[LUT_AW-1:0];
            end
            QD_FALL_POS: begin
                addr = ~idx_i[LUT_AW-1:0];
            end
            QD_FALL_NEG: begin
                neg = 1'b1;
            end
            QD_RISE_NEG: begin
                addr = ~idx_i[LUT_AW-1:0];
                neg  = 1'b1;
            end
        endcase
    end

    logic signed [SINE_W-1:0] mag_s;
    assign mag_s = $signed({1'b0, rom[addr]});

    // Stage 2: signed sine value
    always_ff @(posedge clk) begin
        sine_o <= neg ? -mag_s : mag_s;
        if (rst) begin
            vld_o <= 1'b0;
        end else begin
            vld_o <= vld_i;
        end
    end

    // R5
    quad_sign_chk: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> (sine_o[SINE_W-1] == $past(idx_i[LUT_AW+1])));

endmodule

// File: rtl/dds_width_fit.sv
module dds_width_fit #(
    parameter int SINE_W = 14,
    parameter int OUT_W  = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     vld_i,
    input  logic signed [SINE_W-1:0] din,
    output logic                     vld_o,
    output logic signed [OUT_W-1:0]  dout
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
        end else begin
            vld_o <= vld_i;
        end
    end

    if (OUT_W < SINE_W) begin : g_narrow
        localparam int DROP = SINE_W - OUT_W;
        localparam logic [DROP-1:0] HALF = DROP'(1) << (DROP - 1);
        localparam logic signed [OUT_W-1:0] MAXP = {1'b0, {(OUT_W-1){1'b1}}};

        logic signed [OUT_W-1:0] kept;
        logic [DROP-1:0]         frac;
        logic                    up;

        assign kept = din[SINE_W-1:DROP];
        assign frac = din[DROP-1:0];
        assign up   = (frac > HALF) || ((frac == HALF) && kept[0]);

        always_ff @(posedge clk) begin
            if (up && (kept == MAXP)) begin
                dout <= MAXP;
            end else begin
                dout <= kept + OUT_W'(up);
            end
        end

        // R7
        pos_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
            (vld_o && !$past(din[SINE_W-1])) |-> !dout[OUT_W-1]);
    end else if (OUT_W > SINE_W) begin : g_widen
        localparam int SHIFT = OUT_W - SINE_W;
        always_ff @(posedge clk) begin
            dout <= {din, {SHIFT{1'b0}}};
        end
    end else begin : g_equal
        always_ff @(posedge clk) begin
            dout <= din;
        end
    end

endmodule

// File: rtl/dds_synth.sv
module dds_synth #(
    parameter int PHASE_W = 16,
    parameter int LUT_AW  = 6,
    parameter int SINE_W  = 14,
    parameter int OUT_W   = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    valid,
    input  logic [PHASE_W-1:0]      step,
    input  logic [PHASE_W-1:0]      start,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_sample
);

    localparam int IDX_W = LUT_AW + 2;

    if (PHASE_W < 8 || PHASE_W > 24 || PHASE_W < IDX_W) begin : g_bad_cfg
        $error("dds_synth: unsupported phase width");
    end

    logic                     s1_vld;
    logic [IDX_W-1:0]         s1_idx;
    logic                     s2_vld;
    logic signed [SINE_W-1:0] s2_sine;

    dds_phase_acc #(
        .PHASE_W (PHASE_W),
        .IDX_W   (IDX_W)
    ) i_phase (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .valid (valid),
        .step  (step),
        .start (start),
        .vld_o (s1_vld),
        .idx_o (s1_idx)
    );

    dds_quarter_sine #(
        .LUT_AW (LUT_AW),
        .SINE_W (SINE_W)
    ) i_sine (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (s1_vld),
        .idx_i  (s1_idx),
        .vld_o  (s2_vld),
        .sine_o (s2_sine)
    );

    dds_width_fit #(
        .SINE_W (SINE_W),
        .OUT_W  (OUT_W)
    ) i_fit (
        .clk   (clk),
        .rst   (rst),
        .vld_i (s2_vld),
        .din   (s2_sine),
        .vld_o (out_valid),
        .dout  (out_sample)
    );

    // R4
    out_lat_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(en && valid, 3));

endmodule

// File: tb/test_dds_synth.sv
module test_dds_synth;

    localparam int PW  = 8;
    localparam int AW  = 5;
    localparam int SW  = 12;
    localparam int OWN = 8;
    localparam int OWE = 12;
    localparam int OWW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic valid = 1'b0;
    logic [PW-1:0] step = '0;
    logic [PW-1:0] start = '0;

    logic                  vn, ve, vw;
    logic signed [OWN-1:0] sn;
    logic signed [OWE-1:0] se;
    logic signed [OWW-1:0] sw;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dds_synth #(.PHASE_W(PW), .LUT_AW(AW), .SINE_W(SW), .OUT_W(OWN)) i_dds_synth (
        .clk(clk), .rst(rst), .en(en), .valid(valid), .step(step), .start(start),
        .out_valid(vn), .out_sample(sn));

    dds_synth #(.PHASE_W(PW), .LUT_AW(AW), .SINE_W(SW), .OUT_W(OWE)) i_dds_synth_eq (
        .clk(clk), .rst(rst), .en(en), .valid(valid), .step(step), .start(start),
        .out_valid(ve), .out_sample(se));

    dds_synth #(.PHASE_W(PW), .LUT_AW(AW), .SINE_W(SW), .OUT_W(OWW)) i_dds_synth_wide (
        .clk(clk), .rst(rst), .en(en), .valid(valid), .step(step), .start(start),
        .out_valid(vw), .out_sample(sw));

    // Bench model of the sample pipeline
    int m_acc = 0;
    bit pv [3] = '{0, 0, 0};
    int pph [3] = '{0, 0, 0};

    function automatic int exp_sine(input int k);
        real x, r;
        int  mag;
        x   = 2.0 * 3.14159265358979323846 * (real'(k) + 0.5) / real'(4 << AW);
        r   = real'((1 << (SW - 1)) - 1) * $sin(x);
        mag = $rtoi(((r < 0.0) ? -r : r) + 0.5);
        return (k >= (2 << AW)) ? -mag : mag;
    endfunction

    function automatic int exp_narrow(input int s);
        int d, q, f, h, r;
        d = SW - OWN;
        q = s >>> d;
        f = s - (q << d);
        h = 1 << (d - 1);
        r = q + (((f > h) || ((f == h) && ((q & 1) == 1))) ? 1 : 0);
        if (r > (1 << (OWN - 1)) - 1) r = (1 << (OWN - 1)) - 1;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic e, input logic v);
        int ph, k, s, n, sat;
        en    = e;
        valid = v;
        @(posedge clk);
        pv[2]  = pv[1];  pph[2] = pph[1];
        pv[1]  = pv[0];  pph[1] = pph[0];
        pv[0]  = (!rst) && e && v;
        pph[0] = m_acc;
        if (!e) m_acc = int'(start);
        else if (v) m_acc = (m_acc + int'(step)) % (1 << PW);
        @(negedge clk);
        // R4 latency on every instance
        check(vn == pv[2], "R4 narrow out_valid", int'(vn), int'(pv[2]));
        check(ve == pv[2], "R4 equal out_valid", int'(ve), int'(pv[2]));
        check(vw == pv[2], "R4 wide out_valid", int'(vw), int'(pv[2]));
        if (pv[2]) begin
            ph  = pph[2];
            k   = ph >> (PW - AW - 2);
            s   = exp_sine(k);
            n   = exp_narrow(s);
            sat = ((s >>> (SW - OWN)) == (1 << (OWN - 1)) - 1) && (n == (1 << (OWN - 1)) - 1) ? 1 : 0;
            if (ph % 2 == 1)
                check(int'(se) == s, "R10 odd phase ignores low bit", int'(se), s);
            else
                check(int'(se) == s, "R5 R9 equal-width sine", int'(se), s);
            if (sat == 1)
                check(int'(sn) == n, "R7 saturation", int'(sn), n);
            else
                check(int'(sn) == n, "R6 round half even", int'(sn), n);
            check(int'(sw) == s * (1 << (OWW - SW)), "R8 widen shift", int'(sw), s * (1 << (OWW - SW)));
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R4 actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        // Reset state
        rst = 1'b1;
        repeat (4) cyc(1'b0, 1'b0);
        rst = 1'b0;
        check(vn == 1'b0, "R4 reset out_valid", int'(vn), 0);

        // Full sweep with step 1 from phase 0 (R1, R5..R10)
        start = 8'd0;
        step  = 8'd1;
        cyc(1'b0, 1'b0);
        for (int i = 0; i < 260; i++) cyc(1'b1, 1'b1);
        repeat (3) cyc(1'b1, 1'b0);

        // Coarse wrapping stride from a nonzero start (R1, R2)
        start = 8'd200;
        step  = 8'd37;
        repeat (2) cyc(1'b0, 1'b1);
        for (int i = 0; i < 300; i++) cyc(1'b1, 1'b1);

        // Gaps in valid: phase must hold (R3)
        step = 8'd3;
        for (int i = 0; i < 200; i++) cyc(1'b1, (i % 3) != 1);

        // Drop enable, reload new start, resume (R2)
        repeat (5) cyc(1'b0, 1'b1);
        start = 8'd129;
        step  = 8'd255;
        cyc(1'b0, 1'b0);
        for (int i = 0; i < 150; i++) cyc(1'b1, (i % 5) != 0);
        repeat (4) cyc(1'b0, 1'b0);
        check(vn == 1'b0, "R4 idle out_valid", int'(vn), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule